// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic Inner-Product Unit

This block forms the inner product of a fixed coefficient vector and a variable vector of two's-complement integers, and it uses no multipliers. The coefficients are design parameters. A table of partial sums is built from them when the design is elaborated. After a start request the block loads every input word into its own shift register. It then walks through the words one bit position per clock, least-significant bit first. On each clock the bits taken from all inputs at the current position form a table address. The partial sum read at that address is folded into a right-shifting accumulator. The most significant (sign) position is handled differently: its partial sum is negated by inverting the word and setting the carry-in, so the block subtracts it instead of adding it.

A parameter chooses between one table addressed by all input bits and two smaller tables, each addressed by half of the inputs. In the split form the two table outputs are added before they reach the accumulator. This trades table storage for one extra adder. The full-precision result appears as one parallel word together with a single-cycle completion pulse. The word then holds until the next result replaces it. A start request that arrives during an operation is dropped.

Top module: `da_unit`

## Requirements
- R1: The partial-sum table entry at address A equals the sum of the coefficients of every input i whose bit i of A is 1. Address bit i comes from input i, which is `x_in[i*DATA_W +: DATA_W]`, and coefficient i is `COEFS[i*COEF_W +: COEF_W]`. A vector with a single nonzero input of value 1 therefore returns that input's coefficient.
- R2: The result `y` equals the exact signed integer sum of coef_i times x_i for any two's-complement inputs.
- R3: The sign-position slice is subtracted. An input equal to the most negative value -2^(DATA_W-1) contributes -2^(DATA_W-1) times its coefficient.
- R4: If `start` is sampled high while the block is idle, `done` goes high exactly DATA_W+1 rising edges later (counting the sampling edge). `done` stays high for exactly one cycle, and `busy` falls at that same edge.
- R5: `y` changes only at the edge where `done` rises. At all other times it holds the last result.
- R6: A `start` that arrives while `busy` is high is ignored, and the operation in progress completes with its original inputs.
- R7: The split-table configuration (`SPLIT_ROM`=1) produces the same results and timing as the single-table configuration.
- R8: After a synchronous active-low reset, `done`=0, `busy`=0 and `y`=0.
- R9: Extreme operands, with every input and coefficient at its most negative or most positive value, give the exact result without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to load `x_in` and begin; ignored while busy |
| x_in | input | N_TERMS*DATA_W | Packed two's-complement inputs, input i at bits i*DATA_W |
| busy | output | 1 | High while an inner product is in progress |
| done | output | 1 | One-cycle pulse when `y` is updated |
| y | output | COEF_W+$clog2(N_TERMS)+DATA_W | Signed inner-product result |

## Verification
The bench places the single-table and split-table builds side by side and compares both against an arithmetic dot product. It drives single-input vectors so that each table entry is isolated. A design that mapped address bits to the wrong coefficients would return the wrong coefficient in those cases. Most-negative inputs and all-extreme vectors target the sign-slice subtraction and the guard bit. A design that added the sign slice, or that dropped the guard bit, would return a result with the wrong sign or one that wrapped. The bench also checks the exact cycle of the completion pulse, holds the result between operations, and issues a second start in the middle of an operation. A design that restarted on that second start would finish late and return the second vector's product.

// File: rtl/da_pkg.sv
// Shared helpers for the distributed-arithmetic unit.
// Assumes: callers pass widths no larger than 32 bits for counters.
package da_pkg;
    // Width needed to hold a count from 0 to n-1 (at least one bit).
    function automatic int cnt_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/da_lut.sv
// Partial-sum table: entry a is the sum of the coefficients whose address
// bit is set. The contents are computed from the COEFS parameter during
// elaboration. Assumes NA >= 1 and that COEFS holds NA packed signed words.
module da_lut #(
    parameter int NA     = 2,
    parameter int COEF_W = 8,
    parameter int LUT_W  = COEF_W + $clog2(NA),
    parameter logic [NA*COEF_W-1:0] COEFS = '0
) (
    input  logic [NA-1:0]           addr,
    output logic signed [LUT_W-1:0] word
);
    localparam int DEPTH = 1 << NA;

    function automatic logic signed [LUT_W-1:0] entry(input int a);
        logic signed [LUT_W-1:0] s;
        s = '0;
        for (int i = 0; i < NA; i++) begin
            if (a[i]) s = s + LUT_W'($signed(COEFS[i*COEF_W +: COEF_W]));
        end
        return s;
    endfunction

    logic signed [LUT_W-1:0] table_q [DEPTH];

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        assign table_q[a] = entry(a);
    end

    // Table read.
    assign word = table_q[addr];
endmodule

// File: rtl/da_bit_slicer.sv
// One parallel-load shift register per input word. Each register shifts
// right so that its bit 0 presents the next bit, least-significant first.
// Assumes: load takes priority over shift.
module da_bit_slicer #(
    parameter int N_TERMS = 4,
    parameter int DATA_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic                        shift,
    input  logic [N_TERMS*DATA_W-1:0]   x_in,
    output logic [N_TERMS-1:0]          slice
);
    for (genvar i = 0; i < N_TERMS; i++) begin : g_sr
        logic [DATA_W-1:0] sr_q;

        // Load a word, or move it one place toward the LSB.
        always_ff @(posedge clk) begin
            if (!rst_n)     sr_q <= '0;
            else if (load)  sr_q <= x_in[i*DATA_W +: DATA_W];
            else if (shift) sr_q <= {1'b0, sr_q[DATA_W-1:1]};
        end

        assign slice[i] = sr_q[0];
    end
endmodule

// File: rtl/da_shift_acc.sv
// Shift-accumulator. Each enabled cycle adds the word, or subtracts it
// (invert plus carry-in) when sub is set, to the running sum. It then
// halves the sum and moves the dropped bit into a low-part register. On the
// last cycle the unshifted sum and the low part form the result.
// Assumes DATA_W >= 3 and that word fits ROM_W signed bits.
module da_shift_acc #(
    parameter int ROM_W  = 10,
    parameter int DATA_W = 8,
    parameter int Y_W    = ROM_W + DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     en,
    input  logic                     sub,
    input  logic                     last,
    input  logic signed [ROM_W-1:0]  word,
    output logic signed [Y_W-1:0]    result
);
    localparam int ACC_W = ROM_W + 1;   // one guard bit
    localparam int LOW_W = DATA_W - 1;

    logic signed [ACC_W-1:0] acc_q, wext, sum;
    logic [LOW_W-1:0]        low_q;

    // Add or subtract the partial sum.
    always_comb begin
        wext = ACC_W'(word);
        sum  = acc_q + (sub ? ~wext : wext) + ACC_W'(sub);
    end

    // Running sum and low-part collection.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
            low_q <= '0;
        end else if (en && !last) begin
            acc_q <= sum >>> 1;
            low_q <= {sum[0], low_q[LOW_W-1:1]};
        end
    end

    // Parallel result capture on the final slice.
    always_ff @(posedge clk) begin
        if (!rst_n)          result <= '0;
        else if (en && last) result <= {sum, low_q};
    end
endmodule

// File: rtl/da_unit.sv
// Top of the distributed-arithmetic inner-product unit: sequencing, table
// selection (one table or two half tables), and the shift-accumulator.
// Assumes N_TERMS is even when SPLIT_ROM=1 and DATA_W >= 3.
module da_unit #(
    parameter int N_TERMS   = 4,
    parameter int DATA_W    = 8,
    parameter int COEF_W    = 8,
    parameter bit SPLIT_ROM = 1'b0,
    parameter logic [N_TERMS*COEF_W-1:0] COEFS = 32'h80F5_5521,
    localparam int ROM_W = COEF_W + $clog2(N_TERMS),
    localparam int Y_W   = ROM_W + DATA_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [N_TERMS*DATA_W-1:0]   x_in,
    output logic                        busy,
    output logic                        done,
    output logic signed [Y_W-1:0]       y
);
    localparam int CNT_W = da_pkg::cnt_width(DATA_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]        cnt_q;
    logic                    load, last;
    logic [N_TERMS-1:0]      slice;
    logic signed [ROM_W-1:0] rom_word;

    assign load = start && !busy;
    assign last = busy && (cnt_q == LAST_CNT);

    // Sequencer: accept start when idle, count slices, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
        end else begin
            done <= last;
            if (load) begin
                busy  <= 1'b1;
                cnt_q <= '0;
            end else if (busy) begin
                cnt_q <= cnt_q + 1'b1;
                if (last) busy <= 1'b0;
            end
        end
    end

    da_bit_slicer #(.N_TERMS(N_TERMS), .DATA_W(DATA_W)) u_slicer (
        .clk(clk), .rst_n(rst_n), .load(load), .shift(busy),
        .x_in(x_in), .slice(slice)
    );

    if (SPLIT_ROM) begin : g_split
        localparam int HALF  = N_TERMS / 2;
        localparam int HLF_W = COEF_W + $clog2(HALF);
        logic signed [HLF_W-1:0] lo_word, hi_word;

        da_lut #(.NA(HALF), .COEF_W(COEF_W), .LUT_W(HLF_W),
                 .COEFS(COEFS[HALF*COEF_W-1:0])) u_lut_lo (
            .addr(slice[HALF-1:0]), .word(lo_word)
        );
        da_lut #(.NA(HALF), .COEF_W(COEF_W), .LUT_W(HLF_W),
                 .COEFS(COEFS[N_TERMS*COEF_W-1:HALF*COEF_W])) u_lut_hi (
            .addr(slice[N_TERMS-1:HALF]), .word(hi_word)
        );
        // Sum the two half-table outputs.
        assign rom_word = ROM_W'(lo_word) + ROM_W'(hi_word);
    end else begin : g_full
        da_lut #(.NA(N_TERMS), .COEF_W(COEF_W), .LUT_W(ROM_W),
                 .COEFS(COEFS)) u_lut (
            .addr(slice), .word(rom_word)
        );
    end

    da_shift_acc #(.ROM_W(ROM_W), .DATA_W(DATA_W), .Y_W(Y_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(load), .en(busy),
        .sub(last), .last(last), .word(rom_word), .result(y)
    );
endmodule

// File: rtl/da_unit_chk.sv
// Protocol checker for da_unit, attached with bind.
module da_unit_chk #(
    parameter int Y_W = 18
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic [Y_W-1:0] y
);
    // R4: completion is a single-cycle pulse.
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: busy ends exactly when done is raised.
    a_r4_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R4: the block is idle in the cycle it reports completion.
    a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R5: the result holds except on the completion edge.
    a_r5_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(y));
    // R8: reset clears the status outputs.
    a_r8_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!done && !busy));
endmodule

bind da_unit da_unit_chk #(.Y_W(Y_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .y(y)
);

// File: tb/tb_da_unit.sv
module tb_da_unit;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam logic [N*CW-1:0] CF = 32'h80F5_5521;
    localparam int YW = CW + $clog2(N) + DW;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [N*DW-1:0] x_in = '0;
    logic busy_a, done_a, busy_b, done_b;
    logic signed [YW-1:0] y_a, y_b;
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    da_unit #(.N_TERMS(N), .DATA_W(DW), .COEF_W(CW), .SPLIT_ROM(1'b0),
              .COEFS(CF)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
        .busy(busy_a), .done(done_a), .y(y_a));
    da_unit #(.N_TERMS(N), .DATA_W(DW), .COEF_W(CW), .SPLIT_ROM(1'b1),
              .COEFS(CF)) dut_split (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in),
        .busy(busy_b), .done(done_b), .y(y_b));

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint dot(input logic [N*DW-1:0] xv);
        longint s = 0;
        for (int i = 0; i < N; i++)
            s += longint'($signed(CF[i*CW +: CW])) * longint'($signed(xv[i*DW +: DW]));
        return s;
    endfunction

    // One operation; checks latency (R4), both builds (R2/R7), hold (R5).
    task automatic run(input logic [N*DW-1:0] xv, input string req, input bit poke);
        int cyc = 0;
        longint exp = dot(xv);
        @(negedge clk); x_in = xv; start = 1'b1;
        @(negedge clk); start = 1'b0; cyc = 1;
        if (poke) begin
            x_in = ~xv; start = 1'b1;        // R6: request while busy
            @(negedge clk); start = 1'b0; cyc++;
        end
        while (!done_a && cyc < 40) begin @(negedge clk); cyc++; end
        check({"R4 latency ", req}, cyc, DW + 1);
        check({"R7 split done ", req}, done_b, 1);
        check({"R2 ", req}, y_a, exp);
        check({"R7 split ", req}, y_b, exp);
        @(negedge clk);
        check({"R4 pulse ", req}, done_a, 0);
        check({"R5 hold ", req}, y_a, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 done", done_a, 0);
        check("R8 busy", busy_a, 0);
        check("R8 y", y_a, 0);
        rst_n = 1'b1;
        // R1: isolate each coefficient, R3: most negative input
        for (int i = 0; i < N; i++) begin
            logic [N*DW-1:0] v;
            v = '0; v[i*DW +: DW] = 8'd1;    run(v, "R1 unit", 1'b0);
            v = '0; v[i*DW +: DW] = 8'h80;   run(v, "R3 minval", 1'b0);
            v = '0; v[i*DW +: DW] = 8'hFF;   run(v, "R3 minus1", 1'b0);
            v = '0; v[i*DW +: DW] = 8'h7F;   run(v, "R2 maxval", 1'b0);
        end
        run({N{8'h80}}, "R9 allmin", 1'b0);
        run({N{8'h7F}}, "R9 allmax", 1'b0);
        run({8'h80, 8'h80, 8'h7F, 8'h7F}, "R9 mixed", 1'b0);
        run('0, "R2 zero", 1'b0);
        run({8'h12, 8'h80, 8'h34, 8'hC5}, "R6 ignore", 1'b1);
        for (int r = 0; r < 300; r++) run($urandom, "R2 random", 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule